// File: doc/BRIEF.md
# Banked Scratchpad Conflict Resolver

This block sits in front of a scratchpad built from word-interleaved banks and shared by a group of requesting lanes. It accepts one vector request: a word address and an active bit for each lane, plus a read/write flag and, for writes, one data word per lane. The block works out which lanes collide in a bank. It then issues the vector as the shortest possible run of bank cycles in which no bank is asked for two different words.

The bank is picked by the low bits of the word address, and the remaining bits form the row index driven on that bank's port. In each bank cycle, every bank serves the word of its lowest-numbered pending lane. Every pending lane that asked for that same word is retired together with it, so one fetch is broadcast to all of them. The bank read data comes back one cycle after the enable. When every active lane has been served, the gathered data leaves as one response vector carrying a per-lane valid mask. For a write, lanes that name the same word in the same bank cycle are merged, and the data of the highest-numbered of those lanes is written.

Top module: `scratch_xbar_front`

## Requirements
- R1: Lane address bits [3:0] select the bank (16 banks). Bits [AW-1:4] are driven on that bank's `bank_row`. Read data appears on `bank_rd_data` in the cycle after `bank_rd_en`.
- R2: `req_ready` is high only while the block is idle, and a request is taken on a cycle with `req_valid` and `req_ready` both high. From the cycle after acceptance until the response, `req_ready` is low, and no bank enable is raised while the block is idle.
- R3: In each bank cycle, a bank serves the word of the lowest-numbered still-pending lane that maps to it. The first row issued to a bank is therefore the row of the lowest active lane in that bank.
- R4: All pending lanes that request the word a bank serves in a cycle are retired by that single access. Each of them receives the same data.
- R5: A bank is enabled exactly once per distinct word requested in it. The number of cycles with any bank enable equals the largest count of distinct words in any one bank.
- R6: After the last bank cycle, `rsp_valid` pulses for exactly one cycle. `rsp_data` then holds, for every active lane of a read, the word stored at that lane's address.
- R7: `rsp_lane_valid` equals the active mask of the request. Inactive lanes cause no bank access, and a request with no active lane raises no bank enable and still responds, with an empty mask.
- R8: On a write (`req_write`=1), each distinct word is written once. Where several lanes name the same word, the data of the highest-numbered of those lanes is stored. A bank never sees a read enable and a write enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request vector present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write vector, 0 = read vector |
| req_active | input | LANES | Per-lane active bits |
| req_addr | input | LANES*AW | Per-lane word address |
| req_wdata | input | LANES*DW | Per-lane write data |
| bank_rd_en | output | BANKS | Per-bank read enable |
| bank_wr_en | output | BANKS | Per-bank write enable |
| bank_row | output | BANKS*(AW-4) | Per-bank row index |
| bank_wr_data | output | BANKS*DW | Per-bank write data |
| bank_rd_data | input | BANKS*DW | Per-bank read data, one cycle after enable |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_lane_valid | output | LANES | Lanes carried by the response |
| rsp_data | output | LANES*DW | Per-lane read data |

## Verification
Serialization and broadcast meet in one bank cycle when a bank holds several lanes on one word and other lanes on different words. The served word must then retire every lane that asked for it, while the other words wait for later cycles. Random vectors drawn from narrow address windows, plus directed vectors that mix a repeated word with same-bank neighbours, provoke this. The outcome is judged by the per-bank enable count, the total bank-cycle count and the first row each bank sees, all compared against counts of distinct words that the bench computes itself, and by the per-lane data returned.

// File: rtl/scratch_xbar_pkg.sv
package scratch_xbar_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_ISSUE = 2'd1,
    XS_LAST  = 2'd2,
    XS_RESP  = 2'd3
  } xbar_state_e;

  // bank index of a word address: low bits
  function automatic int unsigned bank_sel(input int unsigned addr, input int unsigned bank_bits);
    return addr & ((32'd1 << bank_bits) - 32'd1);
  endfunction

  // row index inside the bank: remaining high bits
  function automatic int unsigned row_sel(input int unsigned addr, input int unsigned bank_bits);
    return addr >> bank_bits;
  endfunction

endpackage

// File: rtl/xbar_bank_pick.sv
module xbar_bank_pick import scratch_xbar_pkg::*; #(
  parameter int unsigned LANES = 16,
  parameter int unsigned BANKS = 16,
  parameter int unsigned AW    = 10,
  parameter int unsigned DW    = 32,
  parameter int unsigned BANK  = 0
) (
  input  logic [LANES-1:0]         pending,
  input  logic [LANES-1:0][AW-1:0] lane_addr,
  input  logic [LANES-1:0][DW-1:0] lane_wdata,
  output logic                     hit,
  output logic [AW-1:0]            pick_addr,
  output logic [DW-1:0]            pick_wdata,
  output logic [LANES-1:0]         retire
);
  localparam int unsigned BB = $clog2(BANKS);

  always_comb begin
    hit       = 1'b0;
    pick_addr = '0;
    for (int l = 0; l < LANES; l++) begin
      if (!hit && pending[l] && bank_sel(32'(lane_addr[l]), BB) == BANK) begin
        hit       = 1'b1;
        pick_addr = lane_addr[l];
      end
    end
  end

  // every pending lane on the chosen word retires; later lanes overwrite
  // the data so the highest-numbered lane wins on a write
  always_comb begin
    retire     = '0;
    pick_wdata = '0;
    for (int l = 0; l < LANES; l++) begin
      if (hit && pending[l] && lane_addr[l] == pick_addr) begin
        retire[l]  = 1'b1;
        pick_wdata = lane_wdata[l];
      end
    end
  end

endmodule

// File: rtl/xbar_resp_gather.sv
module xbar_resp_gather import scratch_xbar_pkg::*; #(
  parameter int unsigned LANES = 16,
  parameter int unsigned BANKS = 16,
  parameter int unsigned AW    = 10,
  parameter int unsigned DW    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          capture,
  input  logic [LANES-1:0][AW-1:0]  lane_addr,
  input  logic [BANKS-1:0][DW-1:0]  bank_rd_data,
  output logic [LANES-1:0][DW-1:0]  lane_data
);
  localparam int unsigned BB = $clog2(BANKS);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BB-1:0] home;
    assign home = BB'(bank_sel(32'(lane_addr[l]), BB));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_data[l] <= '0;
      end else if (capture[l]) begin
        lane_data[l] <= bank_rd_data[home];
      end
    end
  end

endmodule

// File: rtl/scratch_xbar_front.sv
module scratch_xbar_front import scratch_xbar_pkg::*; #(
  parameter int unsigned LANES = 16,
  parameter int unsigned BANKS = 16,
  parameter int unsigned AW    = 10,
  parameter int unsigned DW    = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic                                req_write,
  input  logic [LANES-1:0]                    req_active,
  input  logic [LANES-1:0][AW-1:0]            req_addr,
  input  logic [LANES-1:0][DW-1:0]            req_wdata,
  output logic [BANKS-1:0]                    bank_rd_en,
  output logic [BANKS-1:0]                    bank_wr_en,
  output logic [BANKS-1:0][AW-$clog2(BANKS)-1:0] bank_row,
  output logic [BANKS-1:0][DW-1:0]            bank_wr_data,
  input  logic [BANKS-1:0][DW-1:0]            bank_rd_data,
  output logic                                rsp_valid,
  output logic [LANES-1:0]                    rsp_lane_valid,
  output logic [LANES-1:0][DW-1:0]            rsp_data
);
  localparam int unsigned BB    = $clog2(BANKS);
  localparam int unsigned ROW_W = AW - BB;

  xbar_state_e state_q, state_d;

  logic [LANES-1:0][AW-1:0] addr_q;
  logic [LANES-1:0][DW-1:0] wdata_q;
  logic [LANES-1:0]         active_q;
  logic [LANES-1:0]         pending_q;
  logic [LANES-1:0]         cap_q;
  logic                     wr_q;

  logic [BANKS-1:0]              pick_hit;
  logic [BANKS-1:0][AW-1:0]      pick_addr;
  logic [BANKS-1:0][DW-1:0]      pick_wdata;
  logic [BANKS-1:0][LANES-1:0]   bank_retire;

  // named events for the checker
  logic             accept;
  logic             issue_cycle;
  logic             all_served;
  logic [LANES-1:0] retire_all;
  logic [LANES-1:0] pending_nxt;

  assign req_ready   = (state_q == XS_IDLE);
  assign accept      = req_valid && req_ready;
  assign issue_cycle = (state_q == XS_ISSUE);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    xbar_bank_pick #(
      .LANES(LANES), .BANKS(BANKS), .AW(AW), .DW(DW), .BANK(b)
    ) u_pick (
      .pending    (pending_q),
      .lane_addr  (addr_q),
      .lane_wdata (wdata_q),
      .hit        (pick_hit[b]),
      .pick_addr  (pick_addr[b]),
      .pick_wdata (pick_wdata[b]),
      .retire     (bank_retire[b])
    );
    assign bank_rd_en[b]   = issue_cycle && pick_hit[b] && !wr_q;
    assign bank_wr_en[b]   = issue_cycle && pick_hit[b] &&  wr_q;
    assign bank_row[b]     = ROW_W'(row_sel(32'(pick_addr[b]), BB));
    assign bank_wr_data[b] = pick_wdata[b];
  end

  always_comb begin
    retire_all = '0;
    for (int b = 0; b < BANKS; b++) begin
      retire_all = retire_all | bank_retire[b];
    end
  end

  assign pending_nxt = pending_q & ~retire_all;
  assign all_served  = issue_cycle && (pending_nxt == '0);

  always_comb begin
    state_d = state_q;
    case (state_q)
      XS_IDLE:  if (accept)     state_d = XS_ISSUE;
      XS_ISSUE: if (all_served) state_d = XS_LAST;
      XS_LAST:                  state_d = XS_RESP;
      XS_RESP:                  state_d = XS_IDLE;
      default:                  state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= XS_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      active_q  <= '0;
      pending_q <= '0;
      wr_q      <= 1'b0;
      cap_q     <= '0;
    end else begin
      state_q <= state_d;
      cap_q   <= (issue_cycle && !wr_q) ? retire_all : '0;
      if (accept) begin
        addr_q    <= req_addr;
        wdata_q   <= req_wdata;
        active_q  <= req_active;
        pending_q <= req_active;
        wr_q      <= req_write;
      end else if (issue_cycle) begin
        pending_q <= pending_nxt;
      end
    end
  end

  xbar_resp_gather #(
    .LANES(LANES), .BANKS(BANKS), .AW(AW), .DW(DW)
  ) u_gather (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture      (cap_q),
    .lane_addr    (addr_q),
    .bank_rd_data (bank_rd_data),
    .lane_data    (rsp_data)
  );

  assign rsp_valid      = (state_q == XS_RESP);
  assign rsp_lane_valid = rsp_valid ? active_q : '0;

endmodule

// File: rtl/scratch_xbar_chk.sv
module scratch_xbar_chk #(
  parameter int unsigned LANES = 16,
  parameter int unsigned BANKS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LANES-1:0] req_active,
  input logic [BANKS-1:0] bank_rd_en,
  input logic [BANKS-1:0] bank_wr_en,
  input logic             rsp_valid,
  input logic [LANES-1:0] rsp_lane_valid,
  input logic             issue_cycle
);
  logic [LANES-1:0] seen_mask;
  int unsigned      busy_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_mask   <= '0;
      busy_cycles <= 0;
    end else if (req_valid && req_ready) begin
      seen_mask   <= req_active;
      busy_cycles <= 0;
    end else if (issue_cycle && (bank_rd_en != '0 || bank_wr_en != '0)) begin
      busy_cycles <= busy_cycles + 1;
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bank_rd_en == '0 && bank_wr_en == '0)); // R2
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_rd_en & bank_wr_en) == '0); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6
  AST_MASK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_lane_valid == seen_mask); // R7
  AST_CYCLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cycles <= LANES); // R5

endmodule

bind scratch_xbar_front scratch_xbar_chk #(.LANES(LANES), .BANKS(BANKS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_active     (req_active),
  .bank_rd_en     (bank_rd_en),
  .bank_wr_en     (bank_wr_en),
  .rsp_valid      (rsp_valid),
  .rsp_lane_valid (rsp_lane_valid),
  .issue_cycle    (issue_cycle)
);

// File: tb/scratch_xbar_front_tb.sv
module scratch_xbar_front_tb;
  localparam int LANES = 16;
  localparam int BANKS = 16;
  localparam int AW    = 10;
  localparam int DW    = 32;
  localparam int RW    = AW - 4;
  localparam int ROWS  = 1 << RW;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [LANES-1:0] req_active = '0;
  logic [LANES-1:0][AW-1:0] req_addr = '0;
  logic [LANES-1:0][DW-1:0] req_wdata = '0;
  logic [BANKS-1:0] bank_rd_en, bank_wr_en;
  logic [BANKS-1:0][RW-1:0] bank_row;
  logic [BANKS-1:0][DW-1:0] bank_wr_data;
  logic [BANKS-1:0][DW-1:0] bank_rd_data;
  logic rsp_valid;
  logic [LANES-1:0] rsp_lane_valid;
  logic [LANES-1:0][DW-1:0] rsp_data;

  always #4 clk = ~clk;

  scratch_xbar_front #(.LANES(LANES), .BANKS(BANKS), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_active(req_active), .req_addr(req_addr),
    .req_wdata(req_wdata), .bank_rd_en(bank_rd_en), .bank_wr_en(bank_wr_en),
    .bank_row(bank_row), .bank_wr_data(bank_wr_data), .bank_rd_data(bank_rd_data),
    .rsp_valid(rsp_valid), .rsp_lane_valid(rsp_lane_valid), .rsp_data(rsp_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic logic [DW-1:0] seed_word(int a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  // bench scratchpad: one-cycle read latency
  logic [DW-1:0] mem [BANKS][ROWS];
  logic [DW-1:0] exp_mem [WORDS];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++)
        for (int r = 0; r < ROWS; r++) mem[b][r] <= seed_word(r * BANKS + b);
      bank_rd_data <= '0;
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        if (bank_wr_en[b]) mem[b][bank_row[b]] <= bank_wr_data[b];
        if (bank_rd_en[b]) bank_rd_data[b] <= mem[b][bank_row[b]];
      end
    end
  end

  // monitor at negedge
  int en_cnt [BANKS];
  int first_row [BANKS];
  int busy_cyc;
  always @(negedge clk) begin
    if ((bank_rd_en | bank_wr_en) != '0) busy_cyc++;
    for (int b = 0; b < BANKS; b++) begin
      if (bank_rd_en[b] || bank_wr_en[b]) begin
        if (en_cnt[b] == 0) first_row[b] = int'(bank_row[b]);
        en_cnt[b]++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // current vector
  logic [AW-1:0] t_addr [LANES];
  logic [DW-1:0] t_wd [LANES];
  logic [LANES-1:0] t_act;
  bit t_wr;

  function automatic int distinct_in_bank(int b);
    int n = 0;
    for (int l = 0; l < LANES; l++) begin
      bit dup = 0;
      if (!t_act[l] || int'(t_addr[l] % BANKS) != b) continue;
      for (int k = 0; k < l; k++)
        if (t_act[k] && t_addr[k] == t_addr[l]) dup = 1;
      if (!dup) n++;
    end
    return n;
  endfunction

  function automatic int lowest_row(int b);
    for (int l = 0; l < LANES; l++)
      if (t_act[l] && int'(t_addr[l] % BANKS) == b) return int'(t_addr[l] / BANKS);
    return -1;
  endfunction

  task automatic run_vec();
    int worst = 0;
    int waitn = 0;
    bit bad_cnt = 0, bad_row = 0, bad_dat = 0;
    @(negedge clk);
    req_write = t_wr;
    req_active = t_act;
    for (int l = 0; l < LANES; l++) begin
      req_addr[l] = t_addr[l];
      req_wdata[l] = t_wd[l];
    end
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    busy_cyc = 0;
    for (int b = 0; b < BANKS; b++) begin en_cnt[b] = 0; first_row[b] = -1; end
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2", "ready low while busy", req_ready, 0);
    while (!rsp_valid && waitn < 64) begin @(negedge clk); waitn++; end
    chk(rsp_valid == 1'b1, "R6", "response arrived", rsp_valid, 1);
    chk(rsp_lane_valid == t_act, "R7", "lane valid mask", rsp_lane_valid, t_act);
    for (int b = 0; b < BANKS; b++) begin
      int d = distinct_in_bank(b);
      if (d > worst) worst = d;
      if (en_cnt[b] != d) bad_cnt = 1;
      if (d > 0 && first_row[b] != lowest_row(b)) bad_row = 1;
    end
    chk(busy_cyc == worst, "R5", "bank cycle count", busy_cyc, worst);
    chk(!bad_cnt, "R5", "per-bank enable count", bad_cnt, 0);
    chk(!bad_row, "R3", "first row per bank (R1 mapping)", bad_row, 0);
    if (t_wr) begin
      for (int l = 0; l < LANES; l++) if (t_act[l]) exp_mem[t_addr[l]] = t_wd[l];
      for (int l = 0; l < LANES; l++)
        if (t_act[l] && mem[t_addr[l] % BANKS][t_addr[l] / BANKS] != exp_mem[t_addr[l]])
          bad_dat = 1;
      chk(!bad_dat, "R8", "stored words, highest lane wins", bad_dat, 0);
    end else begin
      for (int l = 0; l < LANES; l++)
        if (t_act[l] && rsp_data[l] != exp_mem[t_addr[l]]) begin
          bad_dat = 1;
          $display("FAIL R4 lane %0d data: actual %0h expected %0h", l, rsp_data[l], exp_mem[t_addr[l]]);
        end
      checks++;
      if (bad_dat) fails++;
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R6", "single-cycle strobe", rsp_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int a = 0; a < WORDS; a++) exp_mem[a] = seed_word(a);
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready == 1'b1, "R2", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0 && bank_rd_en == '0, "R7", "quiet after reset", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R4: every lane on one word -> one fetch
    t_wr = 0; t_act = '1;
    for (int l = 0; l < LANES; l++) begin t_addr[l] = 10'd37; t_wd[l] = 0; end
    run_vec();
    // R5: all lanes in bank 3, distinct words -> 16 cycles
    for (int l = 0; l < LANES; l++) t_addr[l] = AW'(l * 16 + 3);
    run_vec();
    // stride 1 -> 1 cycle; stride 2 -> 2 cycles
    for (int l = 0; l < LANES; l++) t_addr[l] = AW'(100 + l);
    run_vec();
    for (int l = 0; l < LANES; l++) t_addr[l] = AW'(2 * l);
    run_vec();
    // R4 with serialization: mixed repeated word and bank neighbours
    for (int l = 0; l < LANES; l++) t_addr[l] = (l % 3 == 0) ? 10'd21 : AW'(5 + 16 * (l % 4));
    run_vec();
    // R7: no lane active
    t_act = '0;
    run_vec();
    // R7: sparse active mask with conflicts on inactive lanes
    t_act = 16'hA5A5;
    for (int l = 0; l < LANES; l++) t_addr[l] = AW'(7 + 16 * l);
    run_vec();
    // R8: all lanes write one word, lane 15 wins
    t_wr = 1; t_act = '1;
    for (int l = 0; l < LANES; l++) begin t_addr[l] = 10'd300; t_wd[l] = 32'hC0DE0000 + l; end
    run_vec();
    t_wr = 0; run_vec();

    for (int n = 0; n < 80; n++) begin
      int span;
      span = (n % 3 == 0) ? 16 : ((n % 3 == 1) ? 64 : WORDS);
      t_wr = ($urandom % 4) == 0;
      t_act = ($urandom % 3 == 0) ? 16'($urandom) : '1;
      for (int l = 0; l < LANES; l++) begin
        t_addr[l] = AW'($urandom % span);
        t_wd[l] = $urandom;
      end
      run_vec();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule